// File: doc/BRIEF.md
# Byte/Word Data Access Unit with Strap-Selected Byte Order

This unit sits between a 32-bit processor core and a word-wide data memory that is addressed in bytes. It turns each load or store request from the core into a word-aligned memory access. For byte stores it produces per-lane write strobes. For byte loads it extracts the addressed byte from the returned memory word. Aligned word accesses pass through unchanged. Only byte and aligned word transfers are supported.

The byte order is fixed by a strap pin. The value on the strap is taken on the last clock edge before reset is released. After that it decides, for the whole session, which lane a given byte address maps to. In little-endian order, offset `a` inside a word uses lane `a`, which is bits `8a+7:8a`. In big-endian order it uses lane `3-a`, so offset 0 sits in bits 31:24.

Memory reads are assumed to be synchronous. The memory word arrives on `mem_rdata_i` in the cycle after the read is issued, and the aligned result is presented in that same cycle.

Top module: `byte_lane_unit`

## Requirements
- R1: While `rst_n` is low, the byte order follows `strap_big_i` (1 = big-endian, 0 = little-endian) on each clock edge. After reset is released, changes on the strap have no effect on lane mapping until the next reset.
- R2: For any request, `mem_addr_o` equals `req_addr_i` with bits 1:0 forced to zero, in the same cycle.
- R3: A little-endian byte store (`req_size_i`=0, `req_write_i`=1) does the following in the same cycle: raises `mem_we_o`, sets only strobe bit `req_addr_i[1:0]` of `mem_strb_o`, and drives `req_wdata_i[7:0]` on all four byte lanes of `mem_wdata_o`.
- R4: A big-endian byte store behaves as in R3, except that the only strobe set is bit `3 - req_addr_i[1:0]`.
- R5: A little-endian byte load raises `mem_re_o` in the request cycle. In the next cycle `rd_valid_o` is 1 and `rd_data_o` holds bits `8a+7:8a` of `mem_rdata_i` (a = offset) in bits 7:0, with bits 31:8 set to zero.
- R6: A big-endian byte load behaves as in R5, except that it returns lane `3-a`.
- R7: An aligned word store (`req_size_i`=1, bits 1:0 zero) drives `mem_strb_o` = 4'b1111 and passes `req_wdata_i` to `mem_wdata_o` unchanged, in either byte order.
- R8: An aligned word load returns `mem_rdata_i` unchanged on `rd_data_o`, with `rd_valid_o` high, one cycle after the request, in either byte order.
- R9: A word request with nonzero address bits 1:0 raises `align_err_o` in the same cycle. It keeps `mem_we_o` and `mem_re_o` low and `mem_strb_o` zero, and leaves `rd_valid_o` low in the next cycle.
- R10: With `req_valid_i` low, `mem_we_o`, `mem_re_o`, `align_err_o` and `mem_strb_o` are all zero, and `rd_valid_o` is low in the next cycle.
- R11: During reset, `rd_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| strap_big_i | input | 1 | Byte-order strap, 1 = big-endian, sampled during reset |
| req_valid_i | input | 1 | Access request present |
| req_write_i | input | 1 | 1 = store, 0 = load |
| req_size_i | input | 1 | 0 = byte, 1 = word |
| req_addr_i | input | 32 | Byte address |
| req_wdata_i | input | 32 | Store data; a byte store uses bits 7:0 |
| mem_rdata_i | input | 32 | Memory word, valid the cycle after `mem_re_o` |
| mem_addr_o | output | 32 | Word-aligned memory address |
| mem_we_o | output | 1 | Memory write enable |
| mem_re_o | output | 1 | Memory read enable |
| mem_strb_o | output | 4 | Byte-lane write strobes |
| mem_wdata_o | output | 32 | Lane-placed store data |
| align_err_o | output | 1 | Misaligned word access flag |
| rd_valid_o | output | 1 | Load result valid |
| rd_data_o | output | 32 | Aligned, zero-extended load result |

## Verification
The request-side outputs are combinational: address, enables, strobes, write data and the alignment flag. The bench drives each request on a falling edge and samples these outputs one time unit later, in the same cycle. Load results pass through one register stage. For those, the bench waits through one rising edge, drives the memory word, and samples `rd_valid_o` and `rd_data_o` one time unit after the following falling edge. The strap is checked by changing it in the last reset cycle and again right after release, and then observing which strobe lane a byte store at offset 0 selects.

// File: rtl/byte_lane_pkg.sv
// Package: shared types and constants for the byte/word access unit.
// Assumes byte-sized lanes; data width must be a multiple of the byte width.
package byte_lane_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic {
        ACC_BYTE = 1'b0,
        ACC_WORD = 1'b1
    } acc_size_e;
endpackage

// File: rtl/blu_endian_latch.sv
// Module: blu_endian_latch
// Holds the session byte order. While reset is asserted the register tracks
// the strap, so the value present on the last reset edge is kept afterwards.
// Assumes the strap is stable around reset release.
module blu_endian_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic strap_i,
    output logic big_en_o
);
    logic mode_q;

    // Track the strap during reset, hold it afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= strap_i;
        end
    end

    assign big_en_o = mode_q;

    // R1
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(mode_q));
endmodule

// File: rtl/blu_req_decode.sv
// Module: blu_req_decode
// Combinational request path: aligns the address, checks word alignment,
// computes the byte lane for the latched order, and drives the enables,
// strobes and lane-replicated store data.
// Assumes one request per cycle and a memory with per-lane write enables.
module blu_req_decode
    import byte_lane_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic                         big_en_i,
    input  logic                         valid_i,
    input  logic                         write_i,
    input  acc_size_e                    size_i,
    input  logic [ADDR_W-1:0]            addr_i,
    input  logic [DATA_W-1:0]            wdata_i,
    output logic [ADDR_W-1:0]            mem_addr_o,
    output logic                         mem_we_o,
    output logic                         mem_re_o,
    output logic [DATA_W/BYTE_W-1:0]     strb_o,
    output logic [DATA_W-1:0]            wdata_o,
    output logic [$clog2(DATA_W/BYTE_W)-1:0] lane_o,
    output logic                         err_o,
    output logic                         load_go_o,
    output logic                         load_byte_o
);
    localparam int NB    = DATA_W / BYTE_W;
    localparam int OFF_W = $clog2(NB);
    localparam logic [OFF_W-1:0] LAST_LANE = OFF_W'(NB - 1);

    logic [OFF_W-1:0] off;
    logic             is_byte;
    logic             accept;
    logic             byte_wr;
    logic             word_wr;

    // Offset within the word and the derived lane for the current order.
    always_comb begin
        off     = addr_i[OFF_W-1:0];
        lane_o  = big_en_i ? (LAST_LANE - off) : off;
        is_byte = (size_i == ACC_BYTE);
    end

    // Alignment check and accepted-access decode.
    always_comb begin
        err_o       = valid_i && !is_byte && (off != '0);
        accept      = valid_i && !err_o;
        mem_we_o    = accept && write_i;
        mem_re_o    = accept && !write_i;
        load_go_o   = mem_re_o;
        load_byte_o = is_byte;
        byte_wr     = mem_we_o && is_byte;
        word_wr     = mem_we_o && !is_byte;
        mem_addr_o  = {addr_i[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    end

    // Per-lane strobe and store data.
    for (genvar g = 0; g < NB; g++) begin : g_lane
        always_comb begin
            strb_o[g] = byte_wr ? (lane_o == OFF_W'(g)) : word_wr;
            wdata_o[g*BYTE_W +: BYTE_W] = is_byte ? wdata_i[BYTE_W-1:0]
                                                  : wdata_i[g*BYTE_W +: BYTE_W];
        end
    end
endmodule

// File: rtl/blu_load_align.sv
// Module: blu_load_align
// Remembers the lane and size of an issued load for one cycle and turns
// the returned memory word into the core's result: the selected byte,
// zero-extended, or the full word.
// Assumes read data arrives exactly one cycle after the read enable.
module blu_load_align
    import byte_lane_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              load_go_i,
    input  logic                              load_byte_i,
    input  logic [$clog2(DATA_W/BYTE_W)-1:0]  lane_i,
    input  logic [DATA_W-1:0]                 mem_rdata_i,
    output logic                              rd_valid_o,
    output logic [DATA_W-1:0]                 rd_data_o
);
    localparam int NB    = DATA_W / BYTE_W;
    localparam int OFF_W = $clog2(NB);

    logic             pend_q;
    logic             byte_q;
    logic [OFF_W-1:0] lane_q;
    logic [BYTE_W-1:0] lanes [NB];

    // Capture the pending load's shape.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            byte_q <= 1'b0;
            lane_q <= '0;
        end else begin
            pend_q <= load_go_i;
            byte_q <= load_byte_i;
            lane_q <= lane_i;
        end
    end

    // Split the returned word into byte lanes.
    for (genvar g = 0; g < NB; g++) begin : g_split
        assign lanes[g] = mem_rdata_i[g*BYTE_W +: BYTE_W];
    end

    // Form the result.
    always_comb begin
        rd_valid_o = pend_q;
        if (byte_q) begin
            rd_data_o = {{(DATA_W-BYTE_W){1'b0}}, lanes[lane_q]};
        end else begin
            rd_data_o = mem_rdata_i;
        end
    end

    // R5
    load_result_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_go_i |=> rd_valid_o);
endmodule

// File: rtl/byte_lane_unit.sv
// Module: byte_lane_unit (top)
// Byte/word access unit between a core and a byte-addressed word memory.
// Byte order comes from a strap latched during reset.
// Assumes a synchronous memory with one-cycle read latency.
module byte_lane_unit
    import byte_lane_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      strap_big_i,
    input  logic                      req_valid_i,
    input  logic                      req_write_i,
    input  logic                      req_size_i,
    input  logic [ADDR_W-1:0]         req_addr_i,
    input  logic [DATA_W-1:0]         req_wdata_i,
    input  logic [DATA_W-1:0]         mem_rdata_i,
    output logic [ADDR_W-1:0]         mem_addr_o,
    output logic                      mem_we_o,
    output logic                      mem_re_o,
    output logic [DATA_W/8-1:0]       mem_strb_o,
    output logic [DATA_W-1:0]         mem_wdata_o,
    output logic                      align_err_o,
    output logic                      rd_valid_o,
    output logic [DATA_W-1:0]         rd_data_o
);
    localparam int NB    = DATA_W / BYTE_W;
    localparam int OFF_W = $clog2(NB);

    logic             big_en;
    logic [OFF_W-1:0] lane;
    logic             load_go;
    logic             load_byte;
    acc_size_e        size;

    assign size = acc_size_e'(req_size_i);

    blu_endian_latch u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .strap_i  (strap_big_i),
        .big_en_o (big_en)
    );

    blu_req_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
        .big_en_i    (big_en),
        .valid_i     (req_valid_i),
        .write_i     (req_write_i),
        .size_i      (size),
        .addr_i      (req_addr_i),
        .wdata_i     (req_wdata_i),
        .mem_addr_o  (mem_addr_o),
        .mem_we_o    (mem_we_o),
        .mem_re_o    (mem_re_o),
        .strb_o      (mem_strb_o),
        .wdata_o     (mem_wdata_o),
        .lane_o      (lane),
        .err_o       (align_err_o),
        .load_go_o   (load_go),
        .load_byte_o (load_byte)
    );

    blu_load_align #(.DATA_W(DATA_W)) u_ld (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_go_i   (load_go),
        .load_byte_i (load_byte),
        .lane_i      (lane),
        .mem_rdata_i (mem_rdata_i),
        .rd_valid_o  (rd_valid_o),
        .rd_data_o   (rd_data_o)
    );

    // R3
    byte_strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_write_i && !req_size_i) |-> $countones(mem_strb_o) == 1);

    // R9
    misaligned_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_size_i && (req_addr_i[OFF_W-1:0] != '0))
            |-> (!mem_we_o && !mem_re_o && mem_strb_o == '0));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid_i |-> (!mem_we_o && !mem_re_o && !align_err_o));

    // R7
    word_strobe_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_write_i && req_size_i && (req_addr_i[OFF_W-1:0] == '0))
            |-> (&mem_strb_o));
endmodule

// File: tb/byte_lane_unit_tb_top.sv
// Directed bench for byte_lane_unit; each task runs and checks one scenario.
module byte_lane_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap_big_i = 1'b0;
    logic        req_valid_i = 1'b0;
    logic        req_write_i = 1'b0;
    logic        req_size_i = 1'b0;
    logic [31:0] req_addr_i = '0;
    logic [31:0] req_wdata_i = '0;
    logic [31:0] mem_rdata_i = '0;
    logic [31:0] mem_addr_o;
    logic        mem_we_o;
    logic        mem_re_o;
    logic [3:0]  mem_strb_o;
    logic [31:0] mem_wdata_o;
    logic        align_err_o;
    logic        rd_valid_o;
    logic [31:0] rd_data_o;

    int checks = 0;
    int failures = 0;
    bit cur_big = 1'b0;

    always #5 clk = ~clk;

    byte_lane_unit dut_i (
        .clk(clk), .rst_n(rst_n), .strap_big_i(strap_big_i),
        .req_valid_i(req_valid_i), .req_write_i(req_write_i),
        .req_size_i(req_size_i), .req_addr_i(req_addr_i),
        .req_wdata_i(req_wdata_i), .mem_rdata_i(mem_rdata_i),
        .mem_addr_o(mem_addr_o), .mem_we_o(mem_we_o), .mem_re_o(mem_re_o),
        .mem_strb_o(mem_strb_o), .mem_wdata_o(mem_wdata_o),
        .align_err_o(align_err_o), .rd_valid_o(rd_valid_o),
        .rd_data_o(rd_data_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] lane_of(input logic [1:0] off);
        return cur_big ? 2'(3 - off) : off;
    endfunction

    // Reset with strap flipping: the last reset-cycle value must stick (R1, R11).
    task automatic do_reset(input bit big);
        @(negedge clk);
        rst_n = 1'b0; req_valid_i = 1'b0; strap_big_i = ~big;
        repeat (3) @(negedge clk);
        #1 chk("R11 rd_valid in reset", 32'(rd_valid_o), 32'd0);
        strap_big_i = big;
        @(negedge clk);
        rst_n = 1'b1; strap_big_i = ~big;
        cur_big = big;
        repeat (2) @(negedge clk);
    endtask

    // R1: byte store at offset 0 shows the latched order despite strap change.
    task automatic strap_probe();
        @(negedge clk);
        req_valid_i = 1'b1; req_write_i = 1'b1; req_size_i = 1'b0;
        req_addr_i = 32'h100; req_wdata_i = 32'hA5;
        #1 chk("R1 latched order", 32'(mem_strb_o), cur_big ? 32'h8 : 32'h1);
        req_valid_i = 1'b0;
    endtask

    // R2, R3, R4: byte store lane, strobe and replication.
    task automatic byte_store(input logic [31:0] addr, input logic [7:0] d);
        @(negedge clk);
        req_valid_i = 1'b1; req_write_i = 1'b1; req_size_i = 1'b0;
        req_addr_i = addr; req_wdata_i = {24'hDEAD_BE, d};
        #1;
        chk("R2 word addr", mem_addr_o, {addr[31:2], 2'b00});
        chk(cur_big ? "R4 strobe" : "R3 strobe", 32'(mem_strb_o),
            32'(4'b0001 << lane_of(addr[1:0])));
        chk("R3 we", 32'(mem_we_o), 32'd1);
        chk("R3 replicated data", mem_wdata_o, {4{d}});
        req_valid_i = 1'b0;
    endtask

    // R5, R6: byte load returns the selected lane one cycle later.
    task automatic byte_load(input logic [31:0] addr, input logic [31:0] word);
        logic [1:0] ln;
        ln = lane_of(addr[1:0]);
        @(negedge clk);
        req_valid_i = 1'b1; req_write_i = 1'b0; req_size_i = 1'b0; req_addr_i = addr;
        #1 chk("R5 re", 32'(mem_re_o), 32'd1);
        @(negedge clk);
        req_valid_i = 1'b0; mem_rdata_i = word;
        #1;
        chk(cur_big ? "R6 valid" : "R5 valid", 32'(rd_valid_o), 32'd1);
        chk(cur_big ? "R6 data" : "R5 data", rd_data_o, (word >> (8 * ln)) & 32'hFF);
    endtask

    // R7: aligned word store.
    task automatic word_store(input logic [31:0] addr, input logic [31:0] d);
        @(negedge clk);
        req_valid_i = 1'b1; req_write_i = 1'b1; req_size_i = 1'b1;
        req_addr_i = addr; req_wdata_i = d;
        #1;
        chk("R7 strobe", 32'(mem_strb_o), 32'hF);
        chk("R7 data", mem_wdata_o, d);
        chk("R7 err", 32'(align_err_o), 32'd0);
        req_valid_i = 1'b0;
    endtask

    // R8: aligned word load.
    task automatic word_load(input logic [31:0] addr, input logic [31:0] word);
        @(negedge clk);
        req_valid_i = 1'b1; req_write_i = 1'b0; req_size_i = 1'b1; req_addr_i = addr;
        @(negedge clk);
        req_valid_i = 1'b0; mem_rdata_i = word;
        #1;
        chk("R8 valid", 32'(rd_valid_o), 32'd1);
        chk("R8 data", rd_data_o, word);
    endtask

    // R9: misaligned word access.
    task automatic misaligned(input logic [31:0] addr, input bit wr);
        @(negedge clk);
        req_valid_i = 1'b1; req_write_i = wr; req_size_i = 1'b1;
        req_addr_i = addr; req_wdata_i = 32'h1234_5678;
        #1;
        chk("R9 err", 32'(align_err_o), 32'd1);
        chk("R9 we", 32'(mem_we_o), 32'd0);
        chk("R9 re", 32'(mem_re_o), 32'd0);
        chk("R9 strobe", 32'(mem_strb_o), 32'd0);
        @(negedge clk);
        req_valid_i = 1'b0;
        #1 chk("R9 no result", 32'(rd_valid_o), 32'd0);
    endtask

    // R10: idle cycle.
    task automatic idle_check();
        @(negedge clk);
        req_valid_i = 1'b0; req_write_i = 1'b1; req_size_i = 1'b1; req_addr_i = 32'h3;
        #1;
        chk("R10 quiet", {29'd0, mem_we_o, mem_re_o, align_err_o}, 32'd0);
        chk("R10 strobe", 32'(mem_strb_o), 32'd0);
        @(negedge clk);
        #1 chk("R10 no result", 32'(rd_valid_o), 32'd0);
    endtask

    task automatic run_mode(input bit big);
        do_reset(big);
        strap_probe();
        for (int a = 0; a < 4; a++) byte_store(32'h2000 + 32'(a), 8'h10 + 8'(a));
        for (int a = 0; a < 4; a++) byte_load(32'h3000 + 32'(a), 32'hC3B2_A190);
        word_store(32'h4000, 32'hCAFE_F00D);
        word_load(32'h4004, 32'h0102_0304);
        misaligned(32'h5001, 1'b1);
        misaligned(32'h5002, 1'b0);
        idle_check();
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        run_mode(1'b0);
        run_mode(1'b1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule